// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block gathers byte loads that have already passed an unlock check and holds them in a one-sector staging buffer. A sector spans 128 bytes. The upper address bits pick the sector and the low seven bits pick the byte inside it. The first accepted load fixes the target sector and opens a load phase. Later loads may arrive in any order, and each one restarts an inactivity window that is counted in ticks of an external timebase.

When a full window passes with no new load, the block starts a burn cycle on its behavioural storage array. It first writes all ones across the whole sector. It then writes every staged byte. After that it keeps the busy flag up until the modelled program time has elapsed. Bytes that were never loaded therefore read back as FFh.

The block keeps the address and data of the most recently accepted load, so the external bus is free once a load has been taken. A load that names a different sector during the load phase is dropped and counted as an error. Every load presented while the burn is running is dropped without being counted.

Top module: `sector_prog_seq`

## Requirements
- R1: After reset, busy_o is 0, err_cnt_o is 0 and every array location reads FFh.
- R2: Address bits [AW-1:7] select the sector and bits [6:0] select the byte. Loads in an open load phase may target bytes in any order, and each staged byte is written to {sector, byte}.
- R3: The burn cycle starts on the WIN_TICKS-th tick_i cycle after the last accepted load. Each accepted load restarts the count. busy_o rises in the cycle after the expiring tick.
- R4: The burn cycle erases the entire sector before it writes staged data. Data from an earlier burn of that sector does not survive.
- R5: A byte position that was not loaded during the load phase reads FFh after the burn.
- R6: busy_o stays high for exactly max(PROG_CYC, 256) clock cycles per burn. It falls only after all 128 positions of the sector have been written.
- R7: last_addr_o and last_data_o hold the address and data of the most recently accepted load.
- R8: During a load phase, a load whose sector differs from the first load's sector is ignored. It changes neither the buffer nor last_addr_o, and it adds 1 to err_cnt_o.
- R9: A load presented while busy_o is 1 is ignored. It changes neither the array, last_addr_o, last_data_o nor err_cnt_o.
- R10: A burn writes no location outside its own sector.
- R11: A sector loaded in all 128 positions, in reverse order, reads back the loaded data at every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe that advances the inactivity window |
| ld_valid_i | input | 1 | One-cycle armed byte load |
| ld_addr_i | input | AW | Load address (sector and byte) |
| ld_data_i | input | DW | Load data |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | DW | Array read data, combinational |
| busy_o | output | 1 | Burn cycle in progress |
| last_addr_o | output | AW | Address of the most recent accepted load |
| last_data_o | output | DW | Data of the most recent accepted load |
| err_cnt_o | output | ERR_W | Count of foreign-sector loads |

## Verification
The bench sweeps the whole array of a four-sector configuration after every burn and compares each location with an arithmetic model. A design that skipped the erase would leave stale bytes behind after a partial reprogram. A design that wrote the wrong sector would corrupt a neighbouring sector. The window is probed one tick short of expiry, both before and after a restarting load. A timer that failed to restart, or that expired one tick early, would raise busy too soon. Foreign-sector loads and loads issued during the burn check that the latches and the error count react only to the first kind. The burn length is counted cycle by cycle, so an off-by-one end of cycle is caught.

// File: rtl/sect_pkg.sv
`timescale 1ns/1ps
package sect_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BURN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sect_buf.sv
`timescale 1ns/1ps
module sect_buf #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_vld_o
);
  localparam int N = 1 << IDX_W;

  logic [DW-1:0] slot_data [N];
  logic [N-1:0]  slot_vld;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic          vld_q;
    logic [DW-1:0] dat_q;
    logic          hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        dat_q <= '1;
      end else if (clr_i) begin
        vld_q <= 1'b0;
      end else if (hit) begin
        vld_q <= 1'b1;
        dat_q <= wr_data_i;
      end
    end
    assign slot_data[g] = dat_q;
    assign slot_vld[g]  = vld_q;
  end

  assign rd_data_o = slot_data[rd_idx_i];
  assign rd_vld_o  = slot_vld[rd_idx_i];
endmodule

// File: rtl/win_timer.sv
`timescale 1ns/1ps
module win_timer #(
  parameter int WIN_TICKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + CW'(1);
  end

  // a load in the same cycle as the last tick keeps the window open
  assign expire_o = run_i && tick_i && !restart_i && (cnt_q == LAST);
endmodule

// File: rtl/mem_array.sv
`timescale 1ns/1ps
module mem_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sector_prog_seq.sv
`timescale 1ns/1ps
module sector_prog_seq
  import sect_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 8,
  parameter int IDX_W     = 7,
  parameter int WIN_TICKS = 3,
  parameter int PROG_CYC  = 300,
  parameter int ERR_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_valid_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [DW-1:0]    ld_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             busy_o,
  output logic [AW-1:0]    last_addr_o,
  output logic [DW-1:0]    last_data_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int SECT_W     = AW - IDX_W;
  localparam int SECT_BYTES = 1 << IDX_W;
  localparam int WALK_CYC   = 2 * SECT_BYTES;
  localparam int BURN_CYC   = (PROG_CYC > WALK_CYC) ? PROG_CYC : WALK_CYC;
  localparam int CYC_W      = $clog2(BURN_CYC + 1);
  localparam logic [CYC_W-1:0] CYC_ERASE_END = CYC_W'(SECT_BYTES);
  localparam logic [CYC_W-1:0] CYC_PROG_END  = CYC_W'(WALK_CYC);
  localparam logic [CYC_W-1:0] CYC_LAST      = CYC_W'(BURN_CYC - 1);

  seq_state_e          state_q;
  logic [SECT_W-1:0]   sect_q;
  logic [CYC_W-1:0]    cyc_q;
  logic [AW-1:0]       last_addr_q;
  logic [DW-1:0]       last_data_q;
  logic [ERR_W-1:0]    err_cnt_q;

  logic              in_sect, take, foreign, expire, burn_done;
  logic              erase_ph, prog_ph;
  logic [IDX_W-1:0]  walk_idx;
  logic [DW-1:0]     buf_data;
  logic              buf_vld;
  logic              mem_we;
  logic [DW-1:0]     mem_wdata;

  assign in_sect   = (ld_addr_i[AW-1:IDX_W] == sect_q);
  assign take      = ld_valid_i && ((state_q == ST_IDLE) || ((state_q == ST_LOAD) && in_sect));
  assign foreign   = ld_valid_i && (state_q == ST_LOAD) && !in_sect;
  assign burn_done = (state_q == ST_BURN) && (cyc_q == CYC_LAST);

  win_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_LOAD),
    .restart_i (take),
    .tick_i    (tick_i),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sect_q  <= '0;
      cyc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_LOAD;
          sect_q  <= ld_addr_i[AW-1:IDX_W];
        end
        ST_LOAD: if (expire) begin
          state_q <= ST_BURN;
          cyc_q   <= '0;
        end
        ST_BURN: begin
          cyc_q <= cyc_q + CYC_W'(1);
          if (burn_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_data_q <= '0;
      err_cnt_q   <= '0;
    end else begin
      if (take) begin
        last_addr_q <= ld_addr_i;
        last_data_q <= ld_data_i;
      end
      if (foreign) err_cnt_q <= err_cnt_q + ERR_W'(1);
    end
  end

  // erase walk on cycles [0,SECT), program walk on [SECT,2*SECT), then hold
  assign erase_ph = (state_q == ST_BURN) && (cyc_q < CYC_ERASE_END);
  assign prog_ph  = (state_q == ST_BURN) && !erase_ph && (cyc_q < CYC_PROG_END);
  assign walk_idx = cyc_q[IDX_W-1:0];

  sect_buf #(.IDX_W(IDX_W), .DW(DW)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (burn_done),
    .wr_i      (take),
    .wr_idx_i  (ld_addr_i[IDX_W-1:0]),
    .wr_data_i (ld_data_i),
    .rd_idx_i  (walk_idx),
    .rd_data_o (buf_data),
    .rd_vld_o  (buf_vld)
  );

  assign mem_we    = erase_ph || (prog_ph && buf_vld);
  assign mem_wdata = erase_ph ? '1 : buf_data;

  mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i ({sect_q, walk_idx}),
    .wdata_i (mem_wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign busy_o      = (state_q == ST_BURN);
  assign last_addr_o = last_addr_q;
  assign last_data_o = last_data_q;
  assign err_cnt_o   = err_cnt_q;
endmodule

// File: rtl/sector_prog_seq_chk.sv
`timescale 1ns/1ps
module sector_prog_seq_chk #(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int ERR_W    = 8,
  parameter int BURN_CYC = 300
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             ld_valid_i,
  input logic             busy_o,
  input logic [AW-1:0]    last_addr_o,
  input logic [DW-1:0]    last_data_o,
  input logic [ERR_W-1:0] err_cnt_o
);
  int unsigned busy_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && busy_len != 0) |-> (busy_len == BURN_CYC));

  p_start_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tick_i));

  p_err_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_cnt_o) |-> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

  p_busy_ignores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ld_valid_i) |=> ($stable(last_addr_o) && $stable(last_data_o) && $stable(err_cnt_o)));

  p_latch_on_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(last_addr_o) || !$stable(last_data_o)) |-> ($past(ld_valid_i) && !$past(busy_o)));
endmodule

bind sector_prog_seq sector_prog_seq_chk #(
  .AW(AW), .DW(DW), .ERR_W(ERR_W), .BURN_CYC(BURN_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .ld_valid_i  (ld_valid_i),
  .busy_o      (busy_o),
  .last_addr_o (last_addr_o),
  .last_data_o (last_data_o),
  .err_cnt_o   (err_cnt_o)
);

// File: tb/sector_prog_seq_tb.sv
`timescale 1ns/1ps
module sector_prog_seq_tb;
  localparam int AW = 9, DW = 8, IDX_W = 7, WIN = 3, PROG = 300, ERR_W = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ld_v = 1'b0;
  logic [AW-1:0] ld_a = '0, rd_a = '0;
  logic [DW-1:0] ld_d = '0;
  logic [DW-1:0] rd_d, last_d;
  logic [AW-1:0] last_a;
  logic busy;
  logic [ERR_W-1:0] err_cnt;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] stage [1 << IDX_W];
  logic          staged [1 << IDX_W];

  always #4 clk = ~clk;

  sector_prog_seq #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .WIN_TICKS(WIN),
                    .PROG_CYC(PROG), .ERR_W(ERR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ld_valid_i(ld_v),
    .ld_addr_i(ld_a), .ld_data_i(ld_d), .rd_addr_i(rd_a), .rd_data_o(rd_d),
    .busy_o(busy), .last_addr_o(last_a), .last_data_o(last_d), .err_cnt_o(err_cnt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input int d);
    @(negedge clk); ld_v = 1'b1; ld_a = AW'(a); ld_d = DW'(d);
    @(negedge clk); ld_v = 1'b0;
  endtask

  task automatic stage_load(input int a, input int d);
    load(a, d);
    stage[a % 128] = DW'(d); staged[a % 128] = 1'b1;
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic clear_stage();
    for (int i = 0; i < 128; i++) begin staged[i] = 1'b0; stage[i] = '1; end
  endtask

  // expire window, count busy cycles, optionally poke loads while busy
  task automatic run_burn(input int sect, input bit poke);
    int n = 0;
    logic [AW-1:0] la; logic [ERR_W-1:0] ec;
    pulse_ticks(WIN - 1);
    chk("R3 busy before window end", int'(busy), 0);
    pulse_ticks(1);
    chk("R3 busy after window end", int'(busy), 1);
    la = last_a; ec = err_cnt;
    while (busy && n < 2000) begin
      n++;
      if (poke && (n == 20 || n == 150)) begin
        ld_v = 1'b1; ld_a = AW'(sect * 128 + 5); ld_d = 8'h3C;
      end else ld_v = 1'b0;
      @(negedge clk);
    end
    ld_v = 1'b0;
    chk("R6 busy length", n, PROG);
    if (poke) begin
      chk("R9 last_addr after busy loads", int'(last_a), int'(la));
      chk("R9 err_cnt after busy loads", int'(err_cnt), int'(ec));
    end
    for (int i = 0; i < 128; i++) model[sect * 128 + i] = staged[i] ? stage[i] : 8'hFF;
    clear_stage();
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); rd_a = AW'(a);
      #1 chk(req, int'(rd_d), int'(model[a]));
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    clear_stage();
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy reset", int'(busy), 0);
    chk("R1 err_cnt reset", int'(err_cnt), 0);
    sweep("R1 array erased");

    // R2/R3/R5/R7: sector 1, scattered order, window restart
    stage_load(128 + 100, 8'h11);
    stage_load(128 + 3, 8'h22);
    pulse_ticks(WIN - 1);
    chk("R3 no expiry short of window", int'(busy), 0);
    stage_load(128 + 127, 8'h33);
    pulse_ticks(WIN - 1);
    chk("R3 load restarted window", int'(busy), 0);
    stage_load(128 + 0, 8'h00);
    stage_load(128 + 64, 8'hC7);
    chk("R7 last_addr", int'(last_a), 128 + 64);
    chk("R7 last_data", int'(last_d), 8'hC7);
    run_burn(1, 1'b0);
    sweep("R2 R5 R10 sector 1 scattered");

    // R4/R8/R9: rewrite one byte of sector 1, foreign load, loads while busy
    stage_load(128 + 3, 8'h5A);
    load(256 + 7, 8'hEE);
    chk("R8 err_cnt after foreign", int'(err_cnt), 1);
    chk("R8 last_addr unchanged", int'(last_a), 128 + 3);
    chk("R8 last_data unchanged", int'(last_d), 8'h5A);
    run_burn(1, 1'b1);
    sweep("R4 R8 R9 erase before program");

    // R11: full sector 3 in reverse order
    for (int i = 127; i >= 0; i--) stage_load(384 + i, (i * 37 + 11) % 256);
    run_burn(3, 1'b0);
    sweep("R11 full sector reverse");
    chk("R8 err_cnt final", int'(err_cnt), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule